// File: doc/BRIEF.md
# Paged Virtual Address Translator

This block turns a 32-bit virtual address into a 30-bit physical address. Memory is mapped in 512-byte pages, so the nine low address bits are the byte offset and go straight through to the physical address. Above them the virtual space has three parts. The low quarter holds the first per-process region and the next quarter holds the second per-process region. The upper half is system space, which all processes share. Each part has its own table base and table length, supplied as inputs by the surrounding system. A table entry is one 32-bit word. It holds a valid flag, a 4-bit protection code and a 21-bit frame number.

A small fully associative translation buffer holds recent entries. It is tagged by region and virtual page number. A hit, or a page number past the region's length, is answered combinationally in the cycle of the request. On a miss the block reads the entry through a memory read port. If the entry is valid it is written into the buffer, and the retried lookup answers one cycle later. If the entry is invalid it is answered from the read data and not cached. The requester holds its request stable until `resp_valid`. It can drop the whole buffer, or every entry that matches a given address, with single-cycle pulses.

Top module: `vxl_top`

## Requirements
- R1: On a successful translation, `resp_paddr[8:0]` equals `req_vaddr[8:0]` and `resp_paddr[29:9]` is the entry's frame number, which is entry bits [20:0].
- R2: Bit 31 set selects system space, with page number `vaddr[30:9]`. Otherwise bit 30 selects the second process region (set) or the first one (clear), with page number `vaddr[29:9]`. The entry is read from the region's base plus 4 times the page number.
- R3: A page number greater than or equal to the region's length gives fault code 1 (length) in the request cycle, and no memory read is made.
- R4: On a buffer miss, `mem_rd_req` rises in the cycle after the request and stays high with a stable `mem_rd_addr` until `mem_rd_ack`. `mem_rd_data` is taken in the ack cycle.
- R5: A valid fetched entry is placed in the buffer and the response arrives one cycle after the ack. Later requests to the same page respond in the request cycle with no memory read.
- R6: An entry with its valid flag (bit 31) clear gives fault code 3 (not valid) in the ack cycle when access is allowed. It is not cached, so a repeat request reads memory again.
- R7: Protection code (entry bits [30:27]) holds a read limit in [3:2] and a write limit in [1:0]. Modes are 0 kernel, 1 executive, 2 supervisor and 3 user. A write is allowed when mode <= write limit. A read is allowed when mode <= read limit or mode <= write limit. A denied access gives fault code 2 (access).
- R8: When an entry is both invalid and denied, the fault is code 2, not code 3.
- R9: The buffer holds 8 entries and replaces them round-robin. After 8 fills into an empty buffer, a ninth distinct page evicts only the first one filled.
- R10: An `inv_all` pulse removes every entry, and the next request to any page reads memory.
- R11: An `inv_one` pulse removes only the entry whose region and page match `inv_vaddr`. The same page number in another region is kept.
- R12: During and after reset `resp_valid` and `mem_rd_req` are low and the buffer is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request, held until `resp_valid` |
| req_vaddr | input | 32 | Virtual address |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| req_mode | input | 2 | Privilege mode of the access (0 most privileged) |
| resp_valid | output | 1 | Response present this cycle |
| resp_fault | output | 2 | 0 none, 1 length, 2 access, 3 not valid |
| resp_paddr | output | 30 | Physical address when `resp_fault` is 0 |
| p0_base | input | 30 | Table base of the first process region |
| p0_len | input | 23 | Page count of the first process region |
| p1_base | input | 30 | Table base of the second process region |
| p1_len | input | 23 | Page count of the second process region |
| sys_base | input | 30 | Table base of system space |
| sys_len | input | 23 | Page count of system space |
| inv_all | input | 1 | Drop all buffer entries |
| inv_one | input | 1 | Drop the entry matching `inv_vaddr` |
| inv_vaddr | input | 32 | Address whose entry is dropped |
| mem_rd_req | output | 1 | Table entry read request |
| mem_rd_addr | output | 30 | Byte address of the table entry |
| mem_rd_ack | input | 1 | Read data valid, ends the read |
| mem_rd_data | input | 32 | Table entry word |

## Verification
Each result has a fixed cycle. Hits and length faults respond in the cycle the request is driven. An invalid fetched entry is answered in the cycle the memory acknowledges. A valid fetched entry is answered one cycle after that acknowledge. The bench's memory model acknowledges after a fixed two-cycle latency, so these cases are due 0, 2 and 3 cycles after the request is driven. The bench counts falling edges from the request to the first `resp_valid` and checks that count. It also compares the number of memory reads and the last read address against values computed from the region bases and page numbers.

// File: rtl/vxl_pkg.sv
package vxl_pkg;
    localparam int VA_W   = 32;
    localparam int OFF_W  = 9;
    localparam int PA_W   = 30;
    localparam int PTE_W  = 32;
    localparam int PROT_W = 4;
    localparam int PFN_W  = PA_W - OFF_W;
    localparam int VPN_W  = VA_W - 1 - OFF_W;
    localparam int HI_W   = VA_W - OFF_W;
    localparam int LEN_W  = VPN_W + 1;
    localparam int RSV_W  = PTE_W - 1 - PROT_W - PFN_W;

    typedef enum logic [1:0] {
        RGN_P0  = 2'd0,
        RGN_P1  = 2'd1,
        RGN_SYS = 2'd2
    } rgn_e;

    typedef enum logic [1:0] {
        FLT_NONE = 2'd0,
        FLT_LEN  = 2'd1,
        FLT_ACV  = 2'd2,
        FLT_TNV  = 2'd3
    } flt_e;

    typedef struct packed {
        logic              v;
        logic [PROT_W-1:0] prot;
        logic [RSV_W-1:0]  rsvd;
        logic [PFN_W-1:0]  pfn;
    } pte_t;

    typedef struct packed {
        rgn_e             rgn;
        logic [VPN_W-1:0] vpn;
    } vtag_t;

    typedef struct packed {
        logic [PROT_W-1:0] prot;
        logic [PFN_W-1:0]  pfn;
    } tlb_data_t;

    // va_hi is the address with the byte offset removed
    function automatic vtag_t split_va(input logic [HI_W-1:0] va_hi);
        vtag_t t;
        if (va_hi[HI_W-1]) begin
            t.rgn = RGN_SYS;
            t.vpn = va_hi[HI_W-2:0];
        end else begin
            t.rgn = va_hi[HI_W-2] ? RGN_P1 : RGN_P0;
            t.vpn = {1'b0, va_hi[HI_W-3:0]};
        end
        return t;
    endfunction

    // read limit in [3:2], write limit in [1:0]; write rights imply read rights
    function automatic logic prot_ok(input logic [PROT_W-1:0] prot,
                                     input logic [1:0] mode,
                                     input logic wr);
        if (wr)
            return mode <= prot[1:0];
        return (mode <= prot[3:2]) || (mode <= prot[1:0]);
    endfunction
endpackage

// File: rtl/vxl_region.sv
module vxl_region
    import vxl_pkg::*;
(
    input  logic [HI_W-1:0]  va_hi,
    input  logic [PA_W-1:0]  p0_base,
    input  logic [LEN_W-1:0] p0_len,
    input  logic [PA_W-1:0]  p1_base,
    input  logic [LEN_W-1:0] p1_len,
    input  logic [PA_W-1:0]  sys_base,
    input  logic [LEN_W-1:0] sys_len,
    output vtag_t            tag,
    output logic             len_bad,
    output logic [PA_W-1:0]  pte_addr
);
    logic [PA_W-1:0]  base;
    logic [LEN_W-1:0] len;

    assign tag = split_va(va_hi);

    always_comb begin
        case (tag.rgn)
            RGN_P0:  begin base = p0_base;  len = p0_len;  end
            RGN_P1:  begin base = p1_base;  len = p1_len;  end
            default: begin base = sys_base; len = sys_len; end
        endcase
    end

    assign len_bad  = {1'b0, tag.vpn} >= len;
    assign pte_addr = base + PA_W'({tag.vpn, 2'b00});
endmodule

// File: rtl/vxl_tlb.sv
module vxl_tlb
    import vxl_pkg::*;
#(
    parameter int N = 8
) (
    input  logic      clk,
    input  logic      rst,
    input  vtag_t     lk_tag,
    output logic      lk_hit,
    output tlb_data_t lk_data,
    input  logic      fill_en,
    input  vtag_t     fill_tag,
    input  tlb_data_t fill_data,
    input  logic      inv_all,
    input  logic      inv_one,
    input  vtag_t     inv_tag
);
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

    logic [IDX_W-1:0] ptr_q;
    logic [N-1:0]     vld_vec;
    logic [N-1:0]     hit_vec;
    tlb_data_t        slot_dat [N];

    for (genvar i = 0; i < N; i++) begin : g_slot
        logic      vld;
        vtag_t     tag;
        tlb_data_t dat;

        always_ff @(posedge clk) begin
            if (rst) begin
                vld <= 1'b0;
                tag <= '0;
                dat <= '0;
            end else if (fill_en && ptr_q == IDX_W'(i)) begin
                vld <= 1'b1;
                tag <= fill_tag;
                dat <= fill_data;
            end else if (inv_all || (inv_one && tag == inv_tag)) begin
                vld <= 1'b0;
            end
        end

        assign vld_vec[i]  = vld;
        assign hit_vec[i]  = vld && (tag == lk_tag);
        assign slot_dat[i] = dat;
    end

    always_ff @(posedge clk) begin
        if (rst)
            ptr_q <= '0;
        else if (fill_en)
            ptr_q <= (ptr_q == IDX_W'(N - 1)) ? '0 : ptr_q + 1'b1;
    end

    always_comb begin
        lk_data = '0;
        for (int i = 0; i < N; i++)
            if (hit_vec[i])
                lk_data = tlb_data_t'(lk_data | slot_dat[i]);
    end

    assign lk_hit = |hit_vec;

    AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit_vec)); // R5

    AST_INV_ALL_EMPTY: assert property (@(posedge clk) disable iff (rst)
        inv_all && !fill_en |=> vld_vec == '0); // R10

    AST_FILL_LANDS: assert property (@(posedge clk) disable iff (rst)
        fill_en |=> vld_vec[$past(ptr_q)]); // R9
endmodule

// File: rtl/vxl_walk.sv
module vxl_walk
    import vxl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [PA_W-1:0]   pte_addr,
    input  logic              mem_rd_ack,
    input  logic [PTE_W-1:0]  mem_rd_data,
    output logic              busy,
    output logic              mem_rd_req,
    output logic [PA_W-1:0]   mem_rd_addr,
    output logic              pte_ok,
    output logic              pte_bad,
    output logic [PROT_W-1:0] pte_prot,
    output logic [PFN_W-1:0]  pte_pfn
);
    typedef enum logic {WK_IDLE, WK_FETCH} wk_e;

    wk_e              st_q;
    logic [PA_W-1:0]  addr_q;
    pte_t             pte;
    logic             unused_rsvd;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= WK_IDLE;
            addr_q <= '0;
        end else begin
            case (st_q)
                WK_IDLE: if (start) begin
                    st_q   <= WK_FETCH;
                    addr_q <= pte_addr;
                end
                default: if (mem_rd_ack) st_q <= WK_IDLE;
            endcase
        end
    end

    assign busy        = (st_q == WK_FETCH);
    assign mem_rd_req  = busy;
    assign mem_rd_addr = addr_q;
    assign pte         = pte_t'(mem_rd_data);
    assign pte_ok      = busy && mem_rd_ack && pte.v;
    assign pte_bad     = busy && mem_rd_ack && !pte.v;
    assign pte_prot    = pte.prot;
    assign pte_pfn     = pte.pfn;
    assign unused_rsvd = ^pte.rsvd;

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
        mem_rd_req && !mem_rd_ack |=> mem_rd_req && $stable(mem_rd_addr)); // R4
endmodule

// File: rtl/vxl_top.sv
module vxl_top
    import vxl_pkg::*;
#(
    parameter int TLB_N = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic              req_write,
    input  logic [1:0]        req_mode,
    output logic              resp_valid,
    output logic [1:0]        resp_fault,
    output logic [PA_W-1:0]   resp_paddr,
    input  logic [PA_W-1:0]   p0_base,
    input  logic [LEN_W-1:0]  p0_len,
    input  logic [PA_W-1:0]   p1_base,
    input  logic [LEN_W-1:0]  p1_len,
    input  logic [PA_W-1:0]   sys_base,
    input  logic [LEN_W-1:0]  sys_len,
    input  logic              inv_all,
    input  logic              inv_one,
    input  logic [VA_W-1:0]   inv_vaddr,
    output logic              mem_rd_req,
    output logic [PA_W-1:0]   mem_rd_addr,
    input  logic              mem_rd_ack,
    input  logic [PTE_W-1:0]  mem_rd_data
);
    vtag_t             tag;
    vtag_t             inv_tag;
    logic              len_bad;
    logic [PA_W-1:0]   pte_addr;
    logic              hit;
    tlb_data_t         hit_data;
    logic              busy;
    logic              lk_fire;
    logic              start;
    logic              pte_ok;
    logic              pte_bad;
    logic [PROT_W-1:0] pte_prot;
    logic [PFN_W-1:0]  pte_pfn;
    tlb_data_t         fill_data;
    flt_e              flt;
    logic              unused_inv_off;

    assign inv_tag        = split_va(inv_vaddr[VA_W-1:OFF_W]);
    assign unused_inv_off = ^inv_vaddr[OFF_W-1:0];

    vxl_region u_region (
        .va_hi    (req_vaddr[VA_W-1:OFF_W]),
        .p0_base  (p0_base),
        .p0_len   (p0_len),
        .p1_base  (p1_base),
        .p1_len   (p1_len),
        .sys_base (sys_base),
        .sys_len  (sys_len),
        .tag      (tag),
        .len_bad  (len_bad),
        .pte_addr (pte_addr)
    );

    assign fill_data = '{prot: pte_prot, pfn: pte_pfn};

    vxl_tlb #(.N(TLB_N)) u_tlb (
        .clk       (clk),
        .rst       (rst),
        .lk_tag    (tag),
        .lk_hit    (hit),
        .lk_data   (hit_data),
        .fill_en   (pte_ok),
        .fill_tag  (tag),
        .fill_data (fill_data),
        .inv_all   (inv_all),
        .inv_one   (inv_one),
        .inv_tag   (inv_tag)
    );

    assign lk_fire = req_valid && !busy;
    assign start   = lk_fire && !len_bad && !hit;

    vxl_walk u_walk (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .pte_addr    (pte_addr),
        .mem_rd_ack  (mem_rd_ack),
        .mem_rd_data (mem_rd_data),
        .busy        (busy),
        .mem_rd_req  (mem_rd_req),
        .mem_rd_addr (mem_rd_addr),
        .pte_ok      (pte_ok),
        .pte_bad     (pte_bad),
        .pte_prot    (pte_prot),
        .pte_pfn     (pte_pfn)
    );

    // length beats everything; access denial beats a clear valid flag
    always_comb begin
        resp_valid = 1'b0;
        flt        = FLT_NONE;
        if (lk_fire && len_bad) begin
            resp_valid = 1'b1;
            flt        = FLT_LEN;
        end else if (lk_fire && hit) begin
            resp_valid = 1'b1;
            flt        = prot_ok(hit_data.prot, req_mode, req_write) ? FLT_NONE : FLT_ACV;
        end else if (pte_bad) begin
            resp_valid = 1'b1;
            flt        = prot_ok(pte_prot, req_mode, req_write) ? FLT_TNV : FLT_ACV;
        end
    end

    assign resp_fault = flt;
    assign resp_paddr = (flt == FLT_NONE) ? {hit_data.pfn, req_vaddr[OFF_W-1:0]} : '0;

    AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (rst)
        resp_valid && resp_fault == FLT_NONE |->
            resp_paddr[OFF_W-1:0] == req_vaddr[OFF_W-1:0]); // R1

    AST_LEN_NO_READ: assert property (@(posedge clk) disable iff (rst)
        resp_valid && resp_fault == FLT_LEN |-> !mem_rd_req); // R3

    AST_TNV_ONLY_ON_ACK: assert property (@(posedge clk) disable iff (rst)
        resp_valid && resp_fault == FLT_TNV |-> mem_rd_ack && mem_rd_req); // R6
endmodule

// File: tb/sim_vxl_top.sv
module sim_vxl_top;
    localparam int CLK_PERIOD = 10;
    localparam int MEM_LAT    = 2;
    localparam logic [29:0] B0 = 30'h0000;
    localparam logic [29:0] B1 = 30'h0800;
    localparam logic [29:0] BS = 30'h1000;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_write;
    logic [31:0] req_vaddr;
    logic [1:0]  req_mode;
    logic        resp_valid;
    logic [1:0]  resp_fault;
    logic [29:0] resp_paddr;
    logic        inv_all, inv_one;
    logic [31:0] inv_vaddr;
    logic        mem_rd_req, mem_rd_ack;
    logic [29:0] mem_rd_addr;
    logic [31:0] mem_rd_data;

    logic [31:0] pmem [2048];
    int n_chk = 0, n_fail = 0, n_fetch = 0;
    logic [29:0] last_addr;

    always #(CLK_PERIOD / 2) clk = ~clk;

    vxl_top u0 (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_vaddr(req_vaddr), .req_write(req_write), .req_mode(req_mode),
        .resp_valid(resp_valid), .resp_fault(resp_fault), .resp_paddr(resp_paddr),
        .p0_base(B0), .p0_len(23'd64), .p1_base(B1), .p1_len(23'd64),
        .sys_base(BS), .sys_len(23'd64),
        .inv_all(inv_all), .inv_one(inv_one), .inv_vaddr(inv_vaddr),
        .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
        .mem_rd_ack(mem_rd_ack), .mem_rd_data(mem_rd_data)
    );

    function automatic logic [20:0] pfn_of(input int idx);
        return 21'(idx * 37 + 5);
    endfunction

    function automatic logic [31:0] mk_pte(input logic v, input logic [3:0] prot, input int idx);
        return {v, prot, 6'b0, pfn_of(idx)};
    endfunction

    // memory model: acknowledge MEM_LAT cycles after the request appears
    initial begin
        int wait_cnt;
        wait_cnt    = 0;
        mem_rd_ack  = 1'b0;
        mem_rd_data = '0;
        last_addr   = '0;
        forever begin
            @(negedge clk);
            if (mem_rd_ack) begin
                mem_rd_ack = 1'b0;
            end else if (mem_rd_req) begin
                wait_cnt++;
                if (wait_cnt == MEM_LAT) begin
                    wait_cnt    = 0;
                    mem_rd_ack  = 1'b1;
                    mem_rd_data = pmem[mem_rd_addr[12:2]];
                    last_addr   = mem_rd_addr;
                    n_fetch++;
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic access(input logic [31:0] va, input logic wr, input logic [1:0] md,
                          output logic [1:0] flt, output logic [29:0] pa,
                          output int cyc, output int nf);
        int f0;
        f0 = n_fetch;
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; req_write = wr; req_mode = md;
        cyc = 0;
        forever begin
            #1;
            if (resp_valid || cyc > 40) break;
            cyc++;
            @(negedge clk);
        end
        flt = resp_fault;
        pa  = resp_paddr;
        nf  = n_fetch - f0;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // exp_cyc/exp_nf < 0 skip that check
    task automatic run(input string tag, input logic [31:0] va, input logic wr, input logic [1:0] md,
                       input logic [1:0] exp_flt, input logic [20:0] exp_pfn,
                       input int exp_cyc, input int exp_nf);
        logic [1:0]  flt;
        logic [29:0] pa;
        int cyc, nf;
        access(va, wr, md, flt, pa, cyc, nf);
        chk({tag, " fault"}, 64'(flt), 64'(exp_flt));
        if (exp_flt == 2'd0) chk({tag, " paddr"}, 64'(pa), 64'({exp_pfn, va[8:0]}));
        if (exp_cyc >= 0) chk({tag, " cycles"}, 64'(cyc), 64'(exp_cyc));
        if (exp_nf >= 0) chk({tag, " fetches"}, 64'(nf), 64'(exp_nf));
    endtask

    task automatic pulse_inv_all();
        @(negedge clk); inv_all = 1'b1;
        @(negedge clk); inv_all = 1'b0;
    endtask

    task automatic pulse_inv_one(input logic [31:0] va);
        @(negedge clk); inv_one = 1'b1; inv_vaddr = va;
        @(negedge clk); inv_one = 1'b0;
    endtask

    function automatic logic [31:0] p0va(input int pg, input int off);
        return 32'(pg << 9) | 32'(off);
    endfunction

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        chk("R12 resp_valid in reset", 64'(resp_valid), 64'd0);
        chk("R12 mem_rd_req in reset", 64'(mem_rd_req), 64'd0);
        @(negedge clk); rst = 1'b0;
        #1;
        chk("R12 resp_valid after reset", 64'(resp_valid), 64'd0);
        chk("R12 mem_rd_req after reset", 64'(mem_rd_req), 64'd0);
    endtask

    task automatic t_p0();
        run("R12 R5 R1 first p0 access misses", p0va(3, 'h5A), 1'b0, 2'd3, 2'd0, pfn_of(3), MEM_LAT + 1, 1);
        chk("R4 R2 p0 entry address", 64'(last_addr), 64'(B0 + 30'd12));
        run("R5 repeat hits same cycle", p0va(3, 'h5A), 1'b0, 2'd3, 2'd0, pfn_of(3), 0, 0);
        run("R1 offset 1FF write", p0va(3, 'h1FF), 1'b1, 2'd3, 2'd0, pfn_of(3), 0, 0);
    endtask

    task automatic t_regions();
        run("R2 p1 region", 32'h4000_0000 | p0va(5, 'h11), 1'b0, 2'd0, 2'd0, pfn_of(512 + 5), MEM_LAT + 1, 1);
        chk("R2 p1 entry address", 64'(last_addr), 64'(B1 + 30'd20));
        run("R2 system region", 32'h8000_0000 | p0va(7, 'h0), 1'b0, 2'd0, 2'd0, pfn_of(1024 + 7), MEM_LAT + 1, 1);
        chk("R2 system entry address", 64'(last_addr), 64'(BS + 30'd28));
    endtask

    task automatic t_len();
        run("R3 last page in range", p0va(63, 4), 1'b0, 2'd0, 2'd0, pfn_of(63), MEM_LAT + 1, 1);
        run("R3 page equal to length", p0va(64, 4), 1'b0, 2'd0, 2'd1, '0, 0, 0);
        run("R3 R2 system upper quarter", 32'hC000_0200, 1'b0, 2'd0, 2'd1, '0, 0, 0);
    endtask

    task automatic t_tnv();
        pmem[10] = mk_pte(1'b0, 4'b1111, 10);
        run("R6 invalid entry", p0va(10, 0), 1'b0, 2'd3, 2'd3, '0, MEM_LAT, 1);
        run("R6 invalid not cached", p0va(10, 0), 1'b0, 2'd3, 2'd3, '0, MEM_LAT, 1);
    endtask

    task automatic t_prot();
        pmem[20] = mk_pte(1'b1, 4'b0100, 20);
        run("R7 exec read allowed", p0va(20, 1), 1'b0, 2'd1, 2'd0, pfn_of(20), MEM_LAT + 1, 1);
        run("R7 super read denied", p0va(20, 1), 1'b0, 2'd2, 2'd2, '0, 0, 0);
        run("R7 exec write denied", p0va(20, 1), 1'b1, 2'd1, 2'd2, '0, 0, 0);
        run("R7 kernel write allowed", p0va(20, 1), 1'b1, 2'd0, 2'd0, pfn_of(20), 0, 0);
        run("R7 user read denied", p0va(20, 1), 1'b0, 2'd3, 2'd2, '0, 0, 0);
        pmem[21] = mk_pte(1'b1, 4'b0011, 21);
        run("R7 write right implies read", p0va(21, 2), 1'b0, 2'd3, 2'd0, pfn_of(21), MEM_LAT + 1, 1);
    endtask

    task automatic t_prio();
        pmem[30] = mk_pte(1'b0, 4'b0000, 30);
        run("R8 denied and invalid", p0va(30, 0), 1'b0, 2'd3, 2'd2, '0, MEM_LAT, 1);
        run("R8 allowed and invalid", p0va(30, 0), 1'b0, 2'd0, 2'd3, '0, MEM_LAT, 1);
    endtask

    task automatic t_rr();
        pulse_inv_all();
        for (int p = 40; p < 48; p++) run("R9 fill", p0va(p, 0), 1'b0, 2'd0, 2'd0, pfn_of(p), MEM_LAT + 1, 1);
        for (int p = 40; p < 48; p++) run("R9 all eight resident", p0va(p, 0), 1'b0, 2'd0, 2'd0, pfn_of(p), 0, 0);
        run("R9 ninth page", p0va(48, 0), 1'b0, 2'd0, 2'd0, pfn_of(48), MEM_LAT + 1, 1);
        for (int p = 41; p < 49; p++) run("R9 survivors", p0va(p, 0), 1'b0, 2'd0, 2'd0, pfn_of(p), 0, 0);
        run("R9 oldest evicted", p0va(40, 0), 1'b0, 2'd0, 2'd0, pfn_of(40), MEM_LAT + 1, 1);
    endtask

    task automatic t_inv_all();
        pulse_inv_all();
        run("R10 refetch after flush", p0va(45, 0), 1'b0, 2'd0, 2'd0, pfn_of(45), MEM_LAT + 1, 1);
        run("R10 second page refetched", p0va(46, 0), 1'b0, 2'd0, 2'd0, pfn_of(46), MEM_LAT + 1, 1);
    endtask

    task automatic t_inv_one();
        run("R11 load a", p0va(50, 0), 1'b0, 2'd0, 2'd0, pfn_of(50), -1, -1);
        run("R11 load b", p0va(51, 0), 1'b0, 2'd0, 2'd0, pfn_of(51), -1, -1);
        pulse_inv_one(p0va(50, 'h33));
        pulse_inv_one(32'h4000_0000 | p0va(51, 0));
        run("R11 other entry kept", p0va(51, 0), 1'b0, 2'd0, 2'd0, pfn_of(51), 0, 0);
        run("R11 matching entry dropped", p0va(50, 0), 1'b0, 2'd0, 2'd0, pfn_of(50), MEM_LAT + 1, 1);
    endtask

    initial begin
        for (int i = 0; i < 2048; i++) pmem[i] = mk_pte(1'b1, 4'b1111, i);
        req_valid = 1'b0; req_vaddr = '0; req_write = 1'b0; req_mode = '0;
        inv_all = 1'b0; inv_one = 1'b0; inv_vaddr = '0;
        t_reset();
        t_p0();
        t_regions();
        t_len();
        t_tnv();
        t_prot();
        t_prio();
        t_rr();
        t_inv_all();
        t_inv_one();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule